// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block sits between a processor core and three request sources: a bus-hold request from a DMA engine, a non-maskable interrupt line and a maskable interrupt line. It decides which request wins and in which cycle. The DMA engine gets the bus only when the core marks the end of a machine cycle. Interrupts are only recognised when the core marks the end of an instruction, and only while no DMA request is pending or granted. The order is fixed: DMA first, then the non-maskable line, then the maskable line.

When an interrupt is taken, the block emits a one-cycle take pulse together with the handler address. The non-maskable line always goes to a fixed address. For the maskable line, a two-bit mode input selects one of three ways to find the handler. The address can come from the peripheral, or be a fixed address, or be read as a two-byte vector from a 256-byte table. In table mode, the table base byte is held in a register that software can write. When the maskable interrupt is taken, the block asks the core to clear its interrupt-enable flag. A line that stays asserted is therefore not taken again until software sets the flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `dma_gnt` rises one cycle after a clock edge that sees `dma_req` and `cyc_end` both high, and never without `cyc_end`. It falls one cycle after an edge that sees `dma_req` low while granted.
- R2: No interrupt is recognised while `dma_req` or `dma_gnt` is high. A pending non-maskable request is taken at the first instruction boundary after the grant is released.
- R3: A rising edge on `nmi_pin` is latched until it is serviced. The latched request is taken at an instruction boundary whatever the value of `int_en`: `take` and `take_nmi` pulse with `handler_addr` = `NMI_ADDR` (default 0x0100). A line held high is taken only once.
- R4: When a latched non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one is taken first. The maskable one is taken at a later boundary.
- R5: The maskable line is taken only when `int_pin` and `int_en` are both high at an edge where `instr_end` is high. It is never taken between boundaries.
- R6: In mode 0 (`int_mode` = 2'b00), `handler_addr` equals `periph_addr` as sampled at the recognising boundary.
- R7: In mode 1 (2'b01), and also with code 2'b11, `handler_addr` = `FIX_ADDR` (default 0x0200).
- R8: In mode 2 (2'b10), the block reads the table. It first reads the low byte at {base, type, 0}, then the high byte at {base, type, 1}. `vf_rd` is held with a stable address until `vf_ack` comes. `take` pulses two cycles after the second acknowledge, with `handler_addr` = {high, low}.
- R9: The table base register is loaded from `base_wdata` when `base_wr` is high. It resets to 0x00.
- R10: `ien_clr` pulses together with every maskable take, and never with a non-maskable take.
- R11: `take` is a single-cycle pulse and never occurs while `vf_rd` is high. After reset, `dma_gnt`, `take`, `take_nmi`, `ien_clr` and `vf_rd` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_req | input | 1 | Bus-hold request from the DMA engine |
| cyc_end | input | 1 | Core strobe: last cycle of a machine cycle |
| dma_gnt | output | 1 | Bus granted to the DMA engine |
| instr_end | input | 1 | Core strobe: last cycle of an instruction |
| nmi_pin | input | 1 | Non-maskable request, edge-sensitive |
| int_pin | input | 1 | Maskable request, level-sensitive |
| int_en | input | 1 | Core interrupt-enable flag |
| int_mode | input | 2 | Handler-address mode for the maskable line |
| periph_addr | input | 2*DATA_W | Handler address supplied by the peripheral (mode 0) |
| periph_type | input | TYPE_W | Table index supplied by the peripheral (mode 2) |
| base_wr | input | 1 | Write strobe for the table base register |
| base_wdata | input | DATA_W | Value for the table base register |
| take | output | 1 | One-cycle pulse: interrupt taken |
| take_nmi | output | 1 | With `take`: the source is the non-maskable line |
| ien_clr | output | 1 | Pulse asking the core to clear `int_en` |
| handler_addr | output | 2*DATA_W | Handler start address, valid with `take` |
| vf_rd | output | 1 | Vector-table read request |
| vf_addr | output | 2*DATA_W | Vector-table byte address |
| vf_ack | input | 1 | Read acknowledge; `vf_rdata` is valid with it |
| vf_rdata | input | DATA_W | Vector-table read data |

## Verification
The assertions assume that `vf_ack` only comes while `vf_rd` is high. They also assume the core lowers `int_en` after an `ien_clr` pulse, before it raises `instr_end` again with `int_pin` still high. Both are conditions on the surroundings that the block cannot enforce. The bench raises `vf_ack` only after it has seen `vf_rd`. Every boundary is a single `instr_end` cycle, and once a maskable take has been checked, the bench drops `int_en` before the next boundary. DMA requests are kept apart from table fetches, so a grant never overlaps a fetch in progress.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LO   = 2'd1,
        FS_HI   = 2'd2
    } fetch_st_e;

    localparam logic [1:0] MODE_PERIPH = 2'd0;
    localparam logic [1:0] MODE_FIXED  = 2'd1;
    localparam logic [1:0] MODE_TABLE  = 2'd2;

endpackage

// File: rtl/irq_dma_gate.sv
module irq_dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cyc_end,
    output logic gnt
);
    typedef struct packed {
        logic gnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.gnt) begin
            st_d.gnt = req;
        end else begin
            st_d.gnt = req & cyc_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt = st_q.gnt;
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin;
        st_d.pend = (st_q.pend & ~clr) | (pin & ~st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch
    import irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TYPE_W = 7,
    localparam int VA_W  = DATA_W + TYPE_W + 1,
    localparam int VEC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] base,
    input  logic [TYPE_W-1:0] vtype,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              rd,
    output logic [VA_W-1:0]   addr,
    output logic              busy,
    output logic              done,
    output logic [VEC_W-1:0]  vec
);
    typedef struct packed {
        fetch_st_e         st;
        logic [DATA_W-1:0] base;
        logic [TYPE_W-1:0] vtype;
        logic [DATA_W-1:0] lo;
        logic              done;
        logic [VEC_W-1:0]  vec;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.st)
            FS_IDLE: begin
                if (start) begin
                    st_d.st    = FS_LO;
                    st_d.base  = base;
                    st_d.vtype = vtype;
                end
            end
            FS_LO: begin
                if (ack) begin
                    st_d.lo = rdata;
                    st_d.st = FS_HI;
                end
            end
            FS_HI: begin
                if (ack) begin
                    st_d.vec  = {rdata, st_q.lo};
                    st_d.done = 1'b1;
                    st_d.st   = FS_IDLE;
                end
            end
            default: st_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= FS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd   = (st_q.st != FS_IDLE);
    assign addr = {st_q.base, st_q.vtype, (st_q.st == FS_HI)};
    assign busy = rd | st_q.done;
    assign done = st_q.done;
    assign vec  = st_q.vec;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          TYPE_W   = 7,
    parameter int unsigned NMI_ADDR = 32'h0100,
    parameter int unsigned FIX_ADDR = 32'h0200,
    localparam int HA_W = 2 * DATA_W,
    localparam int VA_W = DATA_W + TYPE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_req,
    input  logic              cyc_end,
    output logic              dma_gnt,
    input  logic              instr_end,
    input  logic              nmi_pin,
    input  logic              int_pin,
    input  logic              int_en,
    input  logic [1:0]        int_mode,
    input  logic [HA_W-1:0]   periph_addr,
    input  logic [TYPE_W-1:0] periph_type,
    input  logic              base_wr,
    input  logic [DATA_W-1:0] base_wdata,
    output logic              take,
    output logic              take_nmi,
    output logic              ien_clr,
    output logic [HA_W-1:0]   handler_addr,
    output logic              vf_rd,
    output logic [VA_W-1:0]   vf_addr,
    input  logic              vf_ack,
    input  logic [DATA_W-1:0] vf_rdata
);
    typedef struct packed {
        logic              take;
        logic              nmi;
        logic              ien_clr;
        logic [HA_W-1:0]   haddr;
        logic [DATA_W-1:0] base;
    } st_t;

    st_t st_d, st_q;

    logic            nmi_pend;
    logic            nmi_clr;
    logic            fetch_start;
    logic            fetch_busy;
    logic            fetch_done;
    logic [HA_W-1:0] fetch_vec;
    logic            recog;

    irq_dma_gate u_dma (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (dma_req),
        .cyc_end (cyc_end),
        .gnt     (dma_gnt)
    );

    irq_nmi_edge u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (nmi_pin),
        .clr   (nmi_clr),
        .pend  (nmi_pend)
    );

    irq_vec_fetch #(
        .DATA_W (DATA_W),
        .TYPE_W (TYPE_W)
    ) u_fetch (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fetch_start),
        .base  (st_q.base),
        .vtype (periph_type),
        .ack   (vf_ack),
        .rdata (vf_rdata),
        .rd    (vf_rd),
        .addr  (vf_addr),
        .busy  (fetch_busy),
        .done  (fetch_done),
        .vec   (fetch_vec)
    );

    // Recognition window: instruction boundary, bus not given away, no fetch
    // in flight, and not in the cycle a take is being signalled.
    assign recog = instr_end & ~dma_req & ~dma_gnt & ~fetch_busy & ~st_q.take;

    always_comb begin
        st_d         = st_q;
        st_d.take    = 1'b0;
        st_d.nmi     = 1'b0;
        st_d.ien_clr = 1'b0;
        nmi_clr      = 1'b0;
        fetch_start  = 1'b0;

        if (base_wr) st_d.base = base_wdata;

        if (fetch_done) begin
            st_d.take    = 1'b1;
            st_d.ien_clr = 1'b1;
            st_d.haddr   = fetch_vec;
        end else if (recog && nmi_pend) begin
            st_d.take  = 1'b1;
            st_d.nmi   = 1'b1;
            st_d.haddr = HA_W'(NMI_ADDR);
            nmi_clr    = 1'b1;
        end else if (recog && int_pin && int_en) begin
            unique case (int_mode)
                MODE_PERIPH: begin
                    st_d.take    = 1'b1;
                    st_d.ien_clr = 1'b1;
                    st_d.haddr   = periph_addr;
                end
                MODE_TABLE: begin
                    fetch_start = 1'b1;
                end
                default: begin
                    st_d.take    = 1'b1;
                    st_d.ien_clr = 1'b1;
                    st_d.haddr   = HA_W'(FIX_ADDR);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take         = st_q.take;
    assign take_nmi     = st_q.nmi;
    assign ien_clr      = st_q.ien_clr;
    assign handler_addr = st_q.haddr;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int          DATA_W   = 8,
    parameter int          TYPE_W   = 7,
    parameter int unsigned NMI_ADDR = 32'h0100,
    localparam int HA_W = 2 * DATA_W,
    localparam int VA_W = DATA_W + TYPE_W + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dma_req,
    input logic            dma_gnt,
    input logic            cyc_end,
    input logic            instr_end,
    input logic            take,
    input logic            take_nmi,
    input logic            ien_clr,
    input logic [HA_W-1:0] handler_addr,
    input logic            vf_rd,
    input logic            vf_ack,
    input logic [VA_W-1:0] vf_addr
);
    AST_GNT_ON_CYCLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_gnt) |-> $past(cyc_end) && $past(dma_req)); // R1
    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_gnt && !dma_req |=> !dma_gnt); // R1
    AST_NMI_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take && take_nmi |-> $past(instr_end) && !$past(dma_gnt) && !$past(dma_req)); // R2
    AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        take && take_nmi |-> handler_addr == HA_W'(NMI_ADDR)); // R3
    AST_NMI_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        take && take_nmi |-> !ien_clr); // R10
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R11
    AST_NO_TAKE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        vf_rd |-> !take); // R11
    AST_VF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vf_rd && !vf_ack |=> vf_rd && $stable(vf_addr)); // R8
    AST_VF_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vf_rd) |-> !vf_addr[0]); // R8
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .DATA_W   (DATA_W),
    .TYPE_W   (TYPE_W),
    .NMI_ADDR (NMI_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_req      (dma_req),
    .dma_gnt      (dma_gnt),
    .cyc_end      (cyc_end),
    .instr_end    (instr_end),
    .take         (take),
    .take_nmi     (take_nmi),
    .ien_clr      (ien_clr),
    .handler_addr (handler_addr),
    .vf_rd        (vf_rd),
    .vf_ack       (vf_ack),
    .vf_addr      (vf_addr)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
    localparam int DW = 8;
    localparam int TW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dma_req = 0, cyc_end = 0, instr_end = 0;
    logic          nmi_pin = 0, int_pin = 0, int_en = 0;
    logic [1:0]    int_mode = 2'd1;
    logic [15:0]   periph_addr = '0;
    logic [TW-1:0] periph_type = '0;
    logic          base_wr = 0;
    logic [DW-1:0] base_wdata = '0;
    logic          vf_ack = 0;
    logic [DW-1:0] vf_rdata = '0;
    logic          dma_gnt, take, take_nmi, ien_clr, vf_rd;
    logic [15:0]   handler_addr, vf_addr;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .cyc_end(cyc_end),
        .dma_gnt(dma_gnt), .instr_end(instr_end), .nmi_pin(nmi_pin),
        .int_pin(int_pin), .int_en(int_en), .int_mode(int_mode),
        .periph_addr(periph_addr), .periph_type(periph_type),
        .base_wr(base_wr), .base_wdata(base_wdata), .take(take),
        .take_nmi(take_nmi), .ien_clr(ien_clr), .handler_addr(handler_addr),
        .vf_rd(vf_rd), .vf_addr(vf_addr), .vf_ack(vf_ack), .vf_rdata(vf_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic boundary();
        instr_end = 1'b1;
        tick();
        instr_end = 1'b0;
    endtask

    task automatic t_reset();
        chk(!dma_gnt && !take && !take_nmi && !ien_clr && !vf_rd, "R11 reset outputs",
            {27'd0, dma_gnt, take, take_nmi, ien_clr, vf_rd}, 32'd0);
    endtask

    task automatic t_base_reset();
        int_mode = 2'd2; periph_type = 7'h01; int_en = 1; int_pin = 1;
        boundary();
        chk(vf_rd && vf_addr == 16'h0002, "R9 base resets to zero", vf_addr, 16'h0002);
        int_en = 0; int_pin = 0;
        vf_ack = 1; vf_rdata = 8'h00; tick();
        tick(); vf_ack = 0;
        tick();
        chk(take && handler_addr == 16'h0000, "R8 zero vector", handler_addr, 16'h0000);
        tick();
    endtask

    task automatic t_dma();
        dma_req = 1; tick(); tick();
        chk(!dma_gnt, "R1 no grant without cycle end", dma_gnt, 0);
        cyc_end = 1; tick(); cyc_end = 0;
        chk(dma_gnt, "R1 grant after cycle end", dma_gnt, 1);
        dma_req = 0; tick();
        chk(!dma_gnt, "R1 grant released", dma_gnt, 0);
    endtask

    task automatic t_holdoff();
        dma_req = 1; cyc_end = 1; tick(); cyc_end = 0;
        nmi_pin = 1; tick(); nmi_pin = 0;
        boundary();
        chk(!take, "R2 no take while granted", take, 0);
        tick();
        chk(!take, "R2 still held off", take, 0);
        dma_req = 0; tick();
        boundary();
        chk(take && take_nmi, "R2 pending nmi taken after release", {take, take_nmi}, 2'b11);
        tick();
    endtask

    task automatic t_nmi();
        int_en = 0;
        nmi_pin = 1; tick();
        boundary();
        chk(take && take_nmi, "R3 nmi taken", {take, take_nmi}, 2'b11);
        chk(handler_addr == 16'h0100, "R3 nmi address", handler_addr, 16'h0100);
        chk(!ien_clr, "R10 nmi keeps flag", ien_clr, 0);
        tick();
        chk(!take, "R11 single pulse", take, 0);
        boundary();
        chk(!take, "R3 held level taken once", take, 0);
        nmi_pin = 0; tick();
    endtask

    task automatic t_priority();
        int_mode = 2'd1; int_pin = 1; int_en = 1;
        nmi_pin = 1; tick(); nmi_pin = 0;
        boundary();
        chk(take && take_nmi, "R4 nmi wins", {take, take_nmi}, 2'b11);
        tick();
        boundary();
        chk(take && !take_nmi && handler_addr == 16'h0200, "R4 int follows", handler_addr, 16'h0200);
        chk(ien_clr, "R10 int clears flag", ien_clr, 1);
        int_en = 0; int_pin = 0; tick();
    endtask

    task automatic t_mask();
        int_mode = 2'd1; int_pin = 1; int_en = 0;
        boundary();
        chk(!take, "R5 masked", take, 0);
        int_en = 1; tick(); tick();
        chk(!take, "R5 not between boundaries", take, 0);
        boundary();
        chk(take && !take_nmi, "R5 enabled taken", {take, take_nmi}, 2'b10);
        int_en = 0; int_pin = 0; tick();
    endtask

    task automatic t_mode0();
        int_mode = 2'd0; periph_addr = 16'hBEEF; int_pin = 1; int_en = 1;
        boundary();
        periph_addr = 16'h0000; int_en = 0; int_pin = 0;
        chk(take && handler_addr == 16'hBEEF, "R6 peripheral address", handler_addr, 16'hBEEF);
        tick();
    endtask

    task automatic t_mode1();
        for (int m = 1; m <= 3; m += 2) begin
            int_mode = 2'(m); int_pin = 1; int_en = 1;
            boundary();
            int_en = 0; int_pin = 0;
            chk(take && handler_addr == 16'h0200, "R7 fixed address", handler_addr, 16'h0200);
            tick();
        end
    endtask

    task automatic t_mode2();
        base_wr = 1; base_wdata = 8'h5A; tick(); base_wr = 0;
        int_mode = 2'd2; periph_type = 7'h13; int_pin = 1; int_en = 1;
        boundary();
        chk(vf_rd && vf_addr == 16'h5A26, "R8 low byte address", vf_addr, 16'h5A26);
        chk(!take, "R8 no take during fetch", take, 0);
        int_en = 0; int_pin = 0;
        tick();
        chk(vf_rd && vf_addr == 16'h5A26, "R8 address held until ack", vf_addr, 16'h5A26);
        vf_ack = 1; vf_rdata = 8'h34; tick();
        chk(vf_rd && vf_addr == 16'h5A27, "R8 high byte address", vf_addr, 16'h5A27);
        vf_rdata = 8'h12; tick(); vf_ack = 0;
        chk(!vf_rd && !take, "R8 fetch finished", {vf_rd, take}, 0);
        tick();
        chk(take && handler_addr == 16'h1234, "R8 vector assembled", handler_addr, 16'h1234);
        chk(ien_clr, "R10 table take clears flag", ien_clr, 1);
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_base_reset();
        t_dma();
        t_holdoff();
        t_nmi();
        t_priority();
        t_mask();
        t_mode0();
        t_mode1();
        t_mode2();
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule